// File: doc/BRIEF.md
# Bank-Switched Microcode Register File

This block is a 256-entry, 32-bit register file for a microcoded processor. A microinstruction names its two source operands and its destination with 8-bit register-select fields. Before any of these fields reaches the storage array, it passes through an address translator. The translator can redirect the low part of the register space to another bank under program control.

A separate 8-bit bank register is loaded through its own port. Whenever a select field points into registers 0 to 63, the bank register is merged into it with a bitwise OR. Fields that point at register 64 or higher reach the array unchanged. Software can therefore move a routine's working set to a different group of registers by reloading one register, without rewriting any microcode field. Both read ports and the write port use the same translation.

Reads are combinational. A write is committed at the rising clock edge. A read that hits the register being written in the same cycle returns the incoming data.

Top module: `orf_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register reads as zero and the bank register holds zero.
- R2: A select value from 64 to 255 addresses that same physical register, whatever the bank register holds.
- R3: A select value from 0 to 63 addresses physical register (select OR bank), combined bit by bit with no carry. With bank 0x03, select 4 reaches register 7 and select 1 reaches register 3. With bank 0x40, select 6 reaches register 70.
- R4: The write select is translated exactly as the read selects are, so data written through a low select can be read back through the corresponding high select.
- R5: A value on `bank_value` with `bank_load` high is captured at the rising edge. It changes the translation from the next cycle onward and has no effect in the cycle in which it is presented.
- R6: When `wr_en` is high and a read port's translated address equals the translated write address, that port returns `wr_data` in the same cycle. This holds for both ports.
- R7: With `wr_en` low, no register changes, whatever `wr_sel` and `wr_data` carry.
- R8: The two read ports select and return data independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_sel | input | 8 | Register-select field for read port A |
| rd_b_sel | input | 8 | Register-select field for read port B |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 8 | Register-select field for the write port |
| wr_data | input | 32 | Write data |
| bank_load | input | 1 | Load strobe for the bank register |
| bank_value | input | 8 | New bank register value |

## Verification
If the bank register is wrong, the error shows at the read ports in the first cycle a low select is used after the bad load. The data comes from, or the write lands in, a register other than the one the requirements name. The bench therefore reads through both a low alias and the direct high address, and mixes the two. A translation that adds instead of ORs, or that misses the 64 boundary, returns zero or stale data at once. A broken write enable or a broken bypass shows in the same cycle or the one after.

// File: rtl/orf_pkg.sv
// Package orf_pkg
// Shared constants and types for the bank-switched register file.
// Assumes a single clock domain. Holds no logic.
package orf_pkg;
    localparam int unsigned ORF_DATA_W   = 32;
    localparam int unsigned ORF_ADDR_W   = 8;
    localparam int unsigned ORF_LOW_SPAN = 64;
    localparam int unsigned ORF_NUM_RD   = 2;

    // Index of each address translator inside the top module.
    typedef enum int unsigned {
        PORT_RD_A = 0,
        PORT_RD_B = 1,
        PORT_WR   = 2
    } orf_port_e;

    localparam int unsigned ORF_NUM_PORTS = 3;
endpackage

// File: rtl/orf_xlate.sv
// Module orf_xlate
// Turns a register-select field into a physical register address.
// Selects below LOW_SPAN get the bank value ORed in.
// All other selects pass through unchanged.
// Assumes LOW_SPAN is no larger than 2**ADDR_W. Purely combinational.
module orf_xlate #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned LOW_SPAN = 64
) (
    input  logic [ADDR_W-1:0] sel,
    input  logic [ADDR_W-1:0] bank,
    output logic [ADDR_W-1:0] phys
);
    localparam logic [ADDR_W:0] LOW_LIM = (ADDR_W+1)'(LOW_SPAN);

    logic in_low;

    // Decide whether the select falls in the bank-switched window.
    always_comb begin
        in_low = ({1'b0, sel} < LOW_LIM);
    end

    // Merge the bank bits into low selects; leave high selects as they are.
    always_comb begin
        if (in_low) begin
            phys = sel | bank;
        end else begin
            phys = sel;
        end
    end
endmodule

// File: rtl/orf_bank_reg.sv
// Module orf_bank_reg
// Holds the bank value that the translators merge into low selects.
// A load is captured at the rising edge, so it acts from the next cycle on.
// Synchronous active-low reset clears it to zero.
module orf_bank_reg #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] bank_q
);
    // Capture a new bank value on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= value;
        end
    end
endmodule

// File: rtl/orf_storage.sv
// Module orf_storage
// Register array with one write port and NUM_RD combinational read ports.
// Addresses arrive already translated.
// A read that matches the address being written in the same cycle returns the write data.
// Synchronous active-low reset clears every entry.
module orf_storage #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NUM_RD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr [NUM_RD],
    output logic [DATA_W-1:0] rdata [NUM_RD]
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the write at the clock edge; clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One read mux per port, with same-cycle write forwarding.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic hit;
        always_comb begin
            hit = we && (waddr == raddr[p]);
        end
        // Return the incoming write data on a hit, else the stored value.
        always_comb begin
            rdata[p] = hit ? wdata : mem[raddr[p]];
        end
    end
endmodule

// File: rtl/orf_regfile.sv
// Module orf_regfile (top)
// Bank-switched register file with two read ports and one write port.
// All three select fields pass through an identical translator driven by the
// bank register. Assumes one clock domain and synchronous active-low reset.
module orf_regfile
    import orf_pkg::*;
#(
    parameter int unsigned DATA_W   = ORF_DATA_W,
    parameter int unsigned ADDR_W   = ORF_ADDR_W,
    parameter int unsigned LOW_SPAN = ORF_LOW_SPAN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_a_sel,
    input  logic [ADDR_W-1:0] rd_b_sel,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bank_load,
    input  logic [ADDR_W-1:0] bank_value
);
    localparam int unsigned NPORT = ORF_NUM_PORTS;
    localparam int unsigned NRD   = ORF_NUM_RD;

    logic [ADDR_W-1:0] bank_q;
    logic [ADDR_W-1:0] sel_vec  [NPORT];
    logic [ADDR_W-1:0] phys_vec [NPORT];
    logic [ADDR_W-1:0] rd_a_phys;
    logic [ADDR_W-1:0] rd_b_phys;
    logic [ADDR_W-1:0] wr_phys;
    logic [ADDR_W-1:0] raddr    [NRD];
    logic [DATA_W-1:0] rdata    [NRD];

    // Gather the three select fields in translator order.
    always_comb begin
        sel_vec[PORT_RD_A] = rd_a_sel;
        sel_vec[PORT_RD_B] = rd_b_sel;
        sel_vec[PORT_WR]   = wr_sel;
    end

    orf_bank_reg #(.ADDR_W(ADDR_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bank_load),
        .value  (bank_value),
        .bank_q (bank_q)
    );

    // One identical translator per port.
    for (genvar t = 0; t < NPORT; t++) begin : g_xl
        orf_xlate #(.ADDR_W(ADDR_W), .LOW_SPAN(LOW_SPAN)) u_xl (
            .sel  (sel_vec[t]),
            .bank (bank_q),
            .phys (phys_vec[t])
        );
    end

    // Name the translated addresses and route them to the array.
    always_comb begin
        rd_a_phys = phys_vec[PORT_RD_A];
        rd_b_phys = phys_vec[PORT_RD_B];
        wr_phys   = phys_vec[PORT_WR];
        raddr[0]  = rd_a_phys;
        raddr[1]  = rd_b_phys;
    end

    orf_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NRD)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_phys),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    // Drive the read data ports.
    always_comb begin
        rd_a_data = rdata[0];
        rd_b_data = rdata[1];
    end
endmodule

// File: rtl/orf_regfile_chk.sv
// Module orf_regfile_chk
// Property checker bound to orf_regfile. Relates the select ports to the
// translated addresses, the bank register to its load port, and the read data
// to writes in the same and the previous cycle.
module orf_regfile_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned LOW_SPAN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_a_sel,
    input logic [ADDR_W-1:0] rd_a_phys,
    input logic [ADDR_W-1:0] rd_b_phys,
    input logic [ADDR_W-1:0] wr_phys,
    input logic [ADDR_W-1:0] bank_q,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              bank_load,
    input logic [ADDR_W-1:0] bank_value
);
    localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(LOW_SPAN);

    // R2
    high_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_a_sel} >= LIM) |-> (rd_a_phys == rd_a_sel));

    // R3
    low_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_a_sel} < LIM) |->
            (((rd_a_phys & rd_a_sel) == rd_a_sel) && ((rd_a_sel | bank_q) == rd_a_phys)));

    // R5
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load |=> (bank_q == $past(bank_value)));

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_load && $past(rst_n)) |=> $stable(bank_q));

    // R6
    fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_phys == rd_a_phys)) |-> (rd_a_data == wr_data));

    // R6
    fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_phys == rd_b_phys)) |-> (rd_b_data == wr_data));

    // R4
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !wr_en && (rd_a_phys == $past(wr_phys)))
            |-> (rd_a_data == $past(wr_data)));
endmodule

bind orf_regfile orf_regfile_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOW_SPAN(LOW_SPAN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_sel   (rd_a_sel),
    .rd_a_phys  (rd_a_phys),
    .rd_b_phys  (rd_b_phys),
    .wr_phys    (wr_phys),
    .bank_q     (bank_q),
    .rd_a_data  (rd_a_data),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .bank_load  (bank_load),
    .bank_value (bank_value)
);

// File: tb/orf_regfile_test.sv
// Bench for orf_regfile: a table of per-cycle vectors, then directed tests
// for reset and boundary selects. Inputs change on the falling edge and the
// combinational read data is sampled 1 ns later.
module orf_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  rd_a_sel, rd_b_sel, wr_sel, bank_value;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, bank_load;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    orf_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bank_load(bank_load), .bank_value(bank_value)
    );

    typedef struct packed {
        logic [15:0] rq;
        logic        ld;
        logic [7:0]  bv;
        logic        we;
        logic [7:0]  ws;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [7:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    localparam logic [31:0] DA = 32'hA100_00A1, DB = 32'hB500_00B5, DC = 32'hC500_00C5;
    localparam logic [31:0] DD = 32'hD100_00D1, DE = 32'hE400_00E4, DF = 32'hF600_00F6;
    localparam int NV = 12;

    localparam vec_t VECS [NV] = '{
        '{"R6", 1'b0, 8'h00, 1'b1, 8'd70, DA, 8'd70, 8'd70, DA, DA},
        '{"R8", 1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd70, 8'd10, DA, 32'd0},
        '{"R5", 1'b1, 8'h80, 1'b1, 8'd5, DB, 8'd5, 8'd133, DB, 32'd0},
        '{"R4", 1'b0, 8'h00, 1'b1, 8'd5, DC, 8'd5, 8'd133, DC, DC},
        '{"R5", 1'b1, 8'h00, 1'b0, 8'd0, 32'd0, 8'd5, 8'd133, DC, DC},
        '{"R3", 1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd5, 8'd133, DB, DC},
        '{"R7", 1'b1, 8'h03, 1'b0, 8'd70, 32'hFFFF_FFFF, 8'd70, 8'd1, DA, 32'd0},
        '{"R3", 1'b0, 8'h00, 1'b1, 8'd1, DD, 8'd1, 8'd3, DD, DD},
        '{"R3", 1'b0, 8'h00, 1'b1, 8'd4, DE, 8'd7, 8'd70, DE, DA},
        '{"R5", 1'b1, 8'h40, 1'b0, 8'd0, 32'd0, 8'd4, 8'd3, DE, DD},
        '{"R2", 1'b0, 8'h00, 1'b1, 8'd66, DF, 8'd2, 8'd64, DF, 32'd0},
        '{"R3", 1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd6, 8'd63, DA, 32'd0}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic [7:0] bv, input logic we,
                         input logic [7:0] ws, input logic [31:0] wd,
                         input logic [7:0] ra, input logic [7:0] rb);
        @(negedge clk);
        bank_load = ld; bank_value = bv; wr_en = we; wr_sel = ws; wr_data = wd;
        rd_a_sel = ra; rd_b_sel = rb;
        #1;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; bank_load = 1'b0; bank_value = '0;
        wr_sel = '0; wr_data = '0; rd_a_sel = '0; rd_b_sel = '0;
        repeat (3) @(posedge clk);
        // R1: contents are zero while reset is held
        drive(1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd0, 8'd200);
        check("R1", "port A during reset", rd_a_data, 32'd0);
        check("R1", "port B during reset", rd_b_data, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ld, VECS[i].bv, VECS[i].we, VECS[i].ws, VECS[i].wd,
                  VECS[i].ra, VECS[i].rb);
            check(string'(VECS[i].rq), $sformatf("vec %0d port A", i), rd_a_data, VECS[i].ea);
            check(string'(VECS[i].rq), $sformatf("vec %0d port B", i), rd_b_data, VECS[i].eb);
        end

        // R1: reset mid-run clears contents and the bank register (bank is 0x40 here)
        drive(1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd70, 8'd66);
        rst_n = 1'b0;
        @(posedge clk);
        drive(1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd70, 8'd66);
        rst_n = 1'b1;
        check("R1", "reg 70 after reset", rd_a_data, 32'd0);
        check("R1", "reg 66 after reset", rd_b_data, 32'd0);
        drive(1'b0, 8'h00, 1'b1, 8'd6, 32'h0000_0066, 8'd0, 8'd0);
        drive(1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd70, 8'd6);
        check("R1", "bank cleared, reg 70 untouched", rd_a_data, 32'd0);
        check("R1", "bank cleared, reg 6 written", rd_b_data, 32'h0000_0066);

        // R2: top register, and select 63 just below the window edge with bank 0
        drive(1'b0, 8'h00, 1'b1, 8'd255, 32'h0000_0255, 8'd0, 8'd0);
        drive(1'b0, 8'h00, 1'b1, 8'd63, 32'h0000_0063, 8'd255, 8'd127);
        check("R2", "reg 255 readback", rd_a_data, 32'h0000_0255);
        check("R2", "reg 127 unaffected", rd_b_data, 32'd0);
        // R3: bank 0x80 folds select 63 onto register 191; R2: 255 still direct
        drive(1'b1, 8'h80, 1'b0, 8'd0, 32'd0, 8'd63, 8'd191);
        check("R3", "select 63 before bank change", rd_a_data, 32'h0000_0063);
        check("R3", "reg 191 empty", rd_b_data, 32'd0);
        drive(1'b0, 8'h00, 1'b1, 8'd63, 32'h0000_0191, 8'd255, 8'd0);
        drive(1'b0, 8'h00, 1'b0, 8'd0, 32'd0, 8'd191, 8'd255);
        check("R4", "low select 63 wrote reg 191", rd_a_data, 32'h0000_0191);
        check("R2", "reg 255 with bank 0x80", rd_b_data, 32'h0000_0255);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule